// File: doc/BRIEF.md
# Single-Wire Bus Host Register Interface

This block is the software-facing half of a single-wire (open-drain, one data line) bus host. It is a 32-bit AXI4-Lite slave holding eight word registers: an instruction word, a control word, an interrupt-enable word, a status word, a receive-data word, a bus-sample word and two constant identity words. The instruction opcode, transmit byte, GO request and soft reset are forwarded to a separate timing sequencer through plain ports. The sequencer's ready, done and presence flags and its received byte come back the same way.

The block raises one level-sensitive interrupt from the ready and done flags, each gated by its own enable bit. Software can also take over the pin: in bypass mode the sequencer is disconnected from the pad, and the pad is driven from two instruction bits as a general-purpose tri-state line. Because the line is open-drain, the pad output is a single pull-low enable. The pin level always passes through a two-flop synchronizer, and software can read it back in either mode.

Top module: `swhost_regif`

## Requirements
- R1: After reset the instruction, control, interrupt-enable, status, receive-data and bus-sample words read 0, `irq` is 0, and `axiBValid` and `axiRValid` are 0.
- R2: Offset 0x18 reads 0x7600_0100 and offset 0x1C reads 0x10EE_4453. Writes to either offset change nothing.
- R3: The instruction word at 0x00 keeps only bit 31 (bypass select), bit 23 (bypass tri-state), bit 16 (bypass level), bits 11:8 (opcode) and bits 7:0 (transmit byte). All other bits read 0. Each byte is written only when its `axiWStrb` bit is set. `seqOpcode` and `seqTxData` show bits 11:8 and 7:0.
- R4: The control word at 0x04 keeps bit 31, driven on `seqSoftRst`, and bit 0, driven on `seqGo`. All other bits read 0.
- R5: The interrupt-enable word at 0x08 keeps bit 4 (ready enable) and bit 0 (done enable). `irq` = (R & bit4) | (D & bit0), where R and D are `seqReady` and `seqDone` as sampled at the previous clock edge.
- R6: The status word at 0x0C reads presence in bit 31, ready in bit 4 and done in bit 0. The receive word at 0x10 reads the received byte in bits 7:0. Both are one-cycle registered copies of the sequencer outputs, and writes to them are ignored.
- R7: Bit 0 of the bus-sample word at 0x14 is `padIn` after two flops, and it is valid in both modes.
- R8: With instruction bit 31 = 0, `padPullLow` follows `seqPullLow`. With bit 31 = 1, `padPullLow` is 1 only when bit 23 = 0 and bit 16 = 0, and otherwise the pin is released.
- R9: An address at or above 0x20, or one that is not word-aligned, is unmapped. A write to it changes nothing, and a read of it returns 0. Every response is OKAY (0).
- R10: A write is accepted only in a cycle where `axiAwValid` and `axiWValid` are both high and no response is pending. `axiBValid` stays high until `axiBReady`. `axiRValid` and `axiRData` hold steady until `axiRReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| axiAwAddr | input | ADDR_W | Write address |
| axiAwValid | input | 1 | Write address valid |
| axiAwReady | output | 1 | Write address ready |
| axiWData | input | 32 | Write data |
| axiWStrb | input | 4 | Write byte strobes |
| axiWValid | input | 1 | Write data valid |
| axiWReady | output | 1 | Write data ready |
| axiBResp | output | 2 | Write response |
| axiBValid | output | 1 | Write response valid |
| axiBReady | input | 1 | Write response ready |
| axiArAddr | input | ADDR_W | Read address |
| axiArValid | input | 1 | Read address valid |
| axiArReady | output | 1 | Read address ready |
| axiRData | output | 32 | Read data |
| axiRResp | output | 2 | Read response |
| axiRValid | output | 1 | Read data valid |
| axiRReady | input | 1 | Read data ready |
| seqOpcode | output | 4 | Opcode to sequencer |
| seqTxData | output | 8 | Transmit byte to sequencer |
| seqGo | output | 1 | GO request to sequencer |
| seqSoftRst | output | 1 | Soft reset to sequencer |
| seqReady | input | 1 | Sequencer ready flag |
| seqDone | input | 1 | Sequencer done flag |
| seqPresence | input | 1 | Presence result |
| seqRxData | input | 8 | Received byte |
| seqPullLow | input | 1 | Sequencer pull-low request |
| padIn | input | 1 | Pin level |
| padPullLow | output | 1 | Pin pull-low enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs partial byte strobes on the instruction word; a design that ignored strobes or stored undefined bits would read back stray ones. It writes to the constant words, to offsets past the map and to unaligned offsets. Decoding only address bits 4:2 would let such a write corrupt a real register, which a read of that register then shows. Each clock it compares `irq` and `padPullLow` against a model that uses the flags seen one edge earlier, so an interrupt taken straight from the inputs, or a bypass mode that drives the pin high, shows up at once. It holds back the ready on read and write responses and raises write address without data; a design that dropped `axiRValid` or accepted half a write would be caught.

// File: rtl/swhost_pkg.sv
package swhost_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_INSTR = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IRQEN = 3'd2;
  localparam logic [IDX_W-1:0] IDX_STAT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_RX    = 3'd4;
  localparam logic [IDX_W-1:0] IDX_PIN   = 3'd5;
  localparam logic [IDX_W-1:0] IDX_VER   = 3'd6;
  localparam logic [IDX_W-1:0] IDX_IDENT = 3'd7;

  localparam logic [DATA_W-1:0] VERSION_WORD = 32'h7600_0100;
  localparam logic [DATA_W-1:0] IDENT_WORD   = 32'h10EE_4453;

  localparam logic [DATA_W-1:0] INSTR_KEEP = 32'h8081_0FFF;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h8000_0001;
  localparam logic [DATA_W-1:0] IRQEN_KEEP = 32'h0000_0011;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic              wrMapped;
    logic [DATA_W-1:0] wrData;
    logic [STRB_W-1:0] wrStrb;
    logic              rdEn;
    logic [IDX_W-1:0]  rdIdx;
    logic              rdMapped;
  } regStrobe_t;
endpackage

// File: rtl/swhost_axi_ctrl.sv
module swhost_axi_ctrl
  import swhost_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   axiAwAddr,
  input  logic                axiAwValid,
  output logic                axiAwReady,
  input  logic [DATA_W-1:0]   axiWData,
  input  logic [STRB_W-1:0]   axiWStrb,
  input  logic                axiWValid,
  output logic                axiWReady,
  output logic [1:0]          axiBResp,
  output logic                axiBValid,
  input  logic                axiBReady,
  input  logic [ADDR_W-1:0]   axiArAddr,
  input  logic                axiArValid,
  output logic                axiArReady,
  output logic [1:0]          axiRResp,
  output logic                axiRValid,
  input  logic                axiRReady,
  output regStrobe_t          strobe
);
  localparam int MAP_TOP = IDX_W + 2;

  logic bValidQ, rValidQ;
  logic awMapped, arMapped;
  logic wrFire, rdFire;

  generate
    if (ADDR_W > MAP_TOP) begin : g_highDecode
      assign awMapped = (axiAwAddr[ADDR_W-1:MAP_TOP] == '0) && (axiAwAddr[1:0] == 2'b00);
      assign arMapped = (axiArAddr[ADDR_W-1:MAP_TOP] == '0) && (axiArAddr[1:0] == 2'b00);
    end else begin : g_flatDecode
      assign awMapped = (axiAwAddr[1:0] == 2'b00);
      assign arMapped = (axiArAddr[1:0] == 2'b00);
    end
  endgenerate

  assign wrFire     = axiAwValid & axiWValid & ~bValidQ;
  assign rdFire     = axiArValid & ~rValidQ;
  assign axiAwReady = wrFire;
  assign axiWReady  = wrFire;
  assign axiArReady = ~rValidQ;
  assign axiBValid  = bValidQ;
  assign axiRValid  = rValidQ;
  assign axiBResp   = RESP_OKAY;
  assign axiRResp   = RESP_OKAY;

  always_comb begin
    strobe.wrEn     = wrFire;
    strobe.wrIdx    = axiAwAddr[MAP_TOP-1:2];
    strobe.wrMapped = awMapped;
    strobe.wrData   = axiWData;
    strobe.wrStrb   = axiWStrb;
    strobe.rdEn     = rdFire;
    strobe.rdIdx    = axiArAddr[MAP_TOP-1:2];
    strobe.rdMapped = arMapped;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValidQ <= 1'b0;
      rValidQ <= 1'b0;
    end else begin
      if (wrFire) bValidQ <= 1'b1;
      else if (axiBReady) bValidQ <= 1'b0;
      if (rdFire) rValidQ <= 1'b1;
      else if (axiRReady) rValidQ <= 1'b0;
    end
  end
endmodule

// File: rtl/swhost_reg_dp.sv
module swhost_reg_dp
  import swhost_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  output logic [DATA_W-1:0] rData,
  output logic [3:0]        seqOpcode,
  output logic [7:0]        seqTxData,
  output logic              seqGo,
  output logic              seqSoftRst,
  input  logic              seqReady,
  input  logic              seqDone,
  input  logic              seqPresence,
  input  logic [7:0]        seqRxData,
  input  logic              seqPullLow,
  input  logic              padIn,
  output logic              padPullLow,
  output logic              irq,
  output logic [1:0]        irqEnables,
  output logic              gpioMode
);
  logic [DATA_W-1:0] instrQ, ctrlQ, irqEnQ, rDataQ, readMux;
  logic readyQ, doneQ, presenceQ;
  logic [7:0] rxQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinLevel;

  function automatic logic [DATA_W-1:0] mergeBytes(
    input logic [DATA_W-1:0] oldV,
    input logic [DATA_W-1:0] newV,
    input logic [STRB_W-1:0] strb,
    input logic [DATA_W-1:0] keep
  );
    logic [DATA_W-1:0] res;
    for (int b = 0; b < STRB_W; b++) begin
      res[8*b +: 8] = strb[b] ? newV[8*b +: 8] : oldV[8*b +: 8];
    end
    return res & keep;
  endfunction

  // register writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ <= '0;
      ctrlQ  <= '0;
      irqEnQ <= '0;
    end else if (strobe.wrEn && strobe.wrMapped) begin
      case (strobe.wrIdx)
        IDX_INSTR: instrQ <= mergeBytes(instrQ, strobe.wrData, strobe.wrStrb, INSTR_KEEP);
        IDX_CTRL:  ctrlQ  <= mergeBytes(ctrlQ, strobe.wrData, strobe.wrStrb, CTRL_KEEP);
        IDX_IRQEN: irqEnQ <= mergeBytes(irqEnQ, strobe.wrData, strobe.wrStrb, IRQEN_KEEP);
        default: ;
      endcase
    end
  end

  // sequencer feedback, captured each cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      doneQ     <= 1'b0;
      presenceQ <= 1'b0;
      rxQ       <= '0;
    end else begin
      readyQ    <= seqReady;
      doneQ     <= seqDone;
      presenceQ <= seqPresence;
      rxQ       <= seqRxData;
    end
  end

  // pin synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
  end
  assign pinLevel = syncQ[SYNC_STAGES-1];

  always_comb begin
    readMux = '0;
    if (strobe.rdMapped) begin
      case (strobe.rdIdx)
        IDX_INSTR: readMux = instrQ;
        IDX_CTRL:  readMux = ctrlQ;
        IDX_IRQEN: readMux = irqEnQ;
        IDX_STAT:  readMux = {presenceQ, 26'b0, readyQ, 3'b0, doneQ};
        IDX_RX:    readMux = {24'b0, rxQ};
        IDX_PIN:   readMux = {31'b0, pinLevel};
        IDX_VER:   readMux = VERSION_WORD;
        IDX_IDENT: readMux = IDENT_WORD;
        default:   readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rDataQ <= '0;
    else if (strobe.rdEn) rDataQ <= readMux;
  end
  assign rData = rDataQ;

  assign seqOpcode  = instrQ[11:8];
  assign seqTxData  = instrQ[7:0];
  assign seqGo      = ctrlQ[0];
  assign seqSoftRst = ctrlQ[31];
  assign gpioMode   = instrQ[31];
  assign irqEnables = {irqEnQ[4], irqEnQ[0]};
  assign irq        = (readyQ & irqEnQ[4]) | (doneQ & irqEnQ[0]);
  // open-drain: bypass only ever pulls low, a 1 releases the line
  assign padPullLow = gpioMode ? (~instrQ[23] & ~instrQ[16]) : seqPullLow;
endmodule

// File: rtl/swhost_regif.sv
module swhost_regif
  import swhost_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] axiAwAddr,
  input  logic              axiAwValid,
  output logic              axiAwReady,
  input  logic [31:0]       axiWData,
  input  logic [3:0]        axiWStrb,
  input  logic              axiWValid,
  output logic              axiWReady,
  output logic [1:0]        axiBResp,
  output logic              axiBValid,
  input  logic              axiBReady,
  input  logic [ADDR_W-1:0] axiArAddr,
  input  logic              axiArValid,
  output logic              axiArReady,
  output logic [31:0]       axiRData,
  output logic [1:0]        axiRResp,
  output logic              axiRValid,
  input  logic              axiRReady,
  output logic [3:0]        seqOpcode,
  output logic [7:0]        seqTxData,
  output logic              seqGo,
  output logic              seqSoftRst,
  input  logic              seqReady,
  input  logic              seqDone,
  input  logic              seqPresence,
  input  logic [7:0]        seqRxData,
  input  logic              seqPullLow,
  input  logic              padIn,
  output logic              padPullLow,
  output logic              irq
);
  regStrobe_t strobe;
  logic [1:0] irqEnables;
  logic gpioMode;

  swhost_axi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .axiAwAddr(axiAwAddr), .axiAwValid(axiAwValid), .axiAwReady(axiAwReady),
    .axiWData(axiWData), .axiWStrb(axiWStrb), .axiWValid(axiWValid), .axiWReady(axiWReady),
    .axiBResp(axiBResp), .axiBValid(axiBValid), .axiBReady(axiBReady),
    .axiArAddr(axiArAddr), .axiArValid(axiArValid), .axiArReady(axiArReady),
    .axiRResp(axiRResp), .axiRValid(axiRValid), .axiRReady(axiRReady),
    .strobe(strobe)
  );

  swhost_reg_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rData(axiRData),
    .seqOpcode(seqOpcode), .seqTxData(seqTxData), .seqGo(seqGo), .seqSoftRst(seqSoftRst),
    .seqReady(seqReady), .seqDone(seqDone), .seqPresence(seqPresence), .seqRxData(seqRxData),
    .seqPullLow(seqPullLow), .padIn(padIn), .padPullLow(padPullLow), .irq(irq),
    .irqEnables(irqEnables), .gpioMode(gpioMode)
  );
endmodule

// File: rtl/swhost_regif_chk.sv
module swhost_regif_chk (
  input logic        clk,
  input logic        rstN,
  input logic        axiAwReady,
  input logic [1:0]  axiBResp,
  input logic        axiBValid,
  input logic        axiBReady,
  input logic [31:0] axiRData,
  input logic [1:0]  axiRResp,
  input logic        axiRValid,
  input logic        axiRReady,
  input logic        seqReady,
  input logic        seqDone,
  input logic        seqPullLow,
  input logic        padPullLow,
  input logic        irq,
  input logic [1:0]  irqEnables,
  input logic        gpioMode
);
  // R10: write response held until taken
  a_r10_bvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    axiBValid && !axiBReady |=> axiBValid);
  // R10: read data held steady until taken
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    axiRValid && !axiRReady |=> axiRValid && $stable(axiRData));
  // R10: no new write while a response is pending
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rstN)
    axiBValid |-> !axiAwReady);
  // R9: every response is OKAY
  a_r9_bresp_okay: assert property (@(posedge clk) disable iff (!rstN)
    axiBValid |-> axiBResp == 2'b00);
  a_r9_rresp_okay: assert property (@(posedge clk) disable iff (!rstN)
    axiRValid |-> axiRResp == 2'b00);
  // R5: interrupt follows the flags of the previous edge
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> irq == (($past(seqReady) & irqEnables[1]) | ($past(seqDone) & irqEnables[0])));
  // R8: sequencer owns the pin outside bypass mode
  a_r8_seq_pass: assert property (@(posedge clk) disable iff (!rstN)
    !gpioMode |-> padPullLow == seqPullLow);
endmodule

bind swhost_regif swhost_regif_chk u_chk (
  .clk(clk), .rstN(rstN), .axiAwReady(axiAwReady), .axiBResp(axiBResp),
  .axiBValid(axiBValid), .axiBReady(axiBReady), .axiRData(axiRData),
  .axiRResp(axiRResp), .axiRValid(axiRValid), .axiRReady(axiRReady),
  .seqReady(seqReady), .seqDone(seqDone), .seqPullLow(seqPullLow),
  .padPullLow(padPullLow), .irq(irq), .irqEnables(irqEnables), .gpioMode(gpioMode)
);

// File: tb/test_swhost_regif.sv
`timescale 1ns/1ps
module test_swhost_regif;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] axiAwAddr = '0, axiArAddr = '0;
  logic axiAwValid = 0, axiWValid = 0, axiBReady = 0, axiArValid = 0, axiRReady = 0;
  logic [31:0] axiWData = '0;
  logic [3:0] axiWStrb = '0;
  logic axiAwReady, axiWReady, axiBValid, axiArReady, axiRValid;
  logic [1:0] axiBResp, axiRResp;
  logic [31:0] axiRData;
  logic [3:0] seqOpcode;
  logic [7:0] seqTxData;
  logic seqGo, seqSoftRst, padPullLow, irq;
  logic seqReady = 0, seqDone = 0, seqPresence = 0, seqPullLow = 0, padIn = 0;
  logic [7:0] seqRxData = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic cmpOn = 1'b0;
  logic readyD = 0, doneD = 0;
  logic [31:0] modelReg [8];

  always #4 clk = ~clk;

  swhost_regif i_swhost_regif (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference flags seen at the previous edge
  always @(posedge clk) begin
    if (!rstN) begin readyD <= 0; doneD <= 0; end
    else begin readyD <= seqReady; doneD <= seqDone; end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn) begin
      check("R5 irq", {31'b0, irq},
            {31'b0, (readyD & modelReg[2][4]) | (doneD & modelReg[2][0])});
      check("R8 pad", {31'b0, padPullLow},
            {31'b0, modelReg[0][31] ? (!modelReg[0][23] && !modelReg[0][16]) : seqPullLow});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] keepOf(input int idx);
    case (idx)
      0: return 32'h8081_0FFF;
      1: return 32'h8000_0001;
      2: return 32'h0000_0011;
      default: return 32'h0;
    endcase
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] addr, input logic [31:0] data, input logic [3:0] strb);
    @(negedge clk);
    axiAwAddr = addr; axiWData = data; axiWStrb = strb;
    axiAwValid = 1; axiWValid = 1;
    @(posedge clk);
    if (addr < 8'h20 && addr[1:0] == 2'b00 && addr[4:2] < 3) begin
      for (int b = 0; b < 4; b++)
        if (strb[b]) modelReg[addr[4:2]][8*b +: 8] = data[8*b +: 8];
      modelReg[addr[4:2]] = modelReg[addr[4:2]] & keepOf(int'(addr[4:2]));
    end
    @(negedge clk);
    axiAwValid = 0; axiWValid = 0;
    check("R10 bvalid raised", {31'b0, axiBValid}, 32'd1);
    check("R9 bresp okay", {30'b0, axiBResp}, 32'd0);
    axiBReady = 1;
    @(posedge clk);
    @(negedge clk);
    axiBReady = 0;
    check("R10 bvalid cleared", {31'b0, axiBValid}, 32'd0);
  endtask

  task automatic doRead(input logic [7:0] addr, input logic [31:0] exp, input string tag, input int hold);
    @(negedge clk);
    axiArAddr = addr; axiArValid = 1;
    @(posedge clk);
    @(negedge clk);
    axiArValid = 0;
    check(tag, axiRData, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R10 rvalid held", {31'b0, axiRValid}, 32'd1);
      check("R10 rdata held", axiRData, exp);
    end
    check("R9 rresp okay", {30'b0, axiRResp}, 32'd0);
    axiRReady = 1;
    @(posedge clk);
    @(negedge clk);
    axiRReady = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) modelReg[i] = '0;
    waitClk(4);
    rstN = 1;
    @(negedge clk);
    check("R1 irq reset", {31'b0, irq}, 32'd0);
    check("R1 bvalid reset", {31'b0, axiBValid}, 32'd0);
    check("R1 rvalid reset", {31'b0, axiRValid}, 32'd0);
    cmpOn = 1;
    for (int i = 0; i < 6; i++) doRead(8'(i * 4), 32'h0, "R1 reset word", 0);
    doRead(8'h18, 32'h7600_0100, "R2 version", 0);
    doRead(8'h1C, 32'h10EE_4453, "R2 ident", 0);
    doWrite(8'h18, 32'h0, 4'hF);
    doWrite(8'h1C, 32'hFFFF_FFFF, 4'hF);
    doRead(8'h18, 32'h7600_0100, "R2 version after write", 0);
    doRead(8'h1C, 32'h10EE_4453, "R2 ident after write", 0);

    // R3 instruction field layout and byte strobes
    doWrite(8'h00, 32'hFFFF_FFFF, 4'b0010);
    doRead(8'h00, 32'h0000_0F00, "R3 strobe byte1", 0);
    check("R3 opcode", {28'b0, seqOpcode}, 32'hF);
    check("R3 txdata untouched", {24'b0, seqTxData}, 32'h0);
    doWrite(8'h00, 32'h1234_5A6B, 4'hF);
    doRead(8'h00, 32'h0000_0A6B, "R3 masked word", 0);
    check("R3 opcode", {28'b0, seqOpcode}, 32'hA);
    check("R3 txdata", {24'b0, seqTxData}, 32'h6B);

    // R4 control
    doWrite(8'h04, 32'h8000_0001, 4'hF);
    check("R4 softrst", {31'b0, seqSoftRst}, 32'd1);
    check("R4 go", {31'b0, seqGo}, 32'd1);
    doWrite(8'h04, 32'hFFFF_FFFE, 4'hF);
    doRead(8'h04, 32'h8000_0000, "R4 readback", 0);
    check("R4 go cleared", {31'b0, seqGo}, 32'd0);

    // R6 status and receive data
    @(negedge clk);
    seqReady = 1; seqPresence = 1; seqDone = 0; seqRxData = 8'hA5;
    waitClk(2);
    doRead(8'h0C, 32'h8000_0010, "R6 status", 0);
    doRead(8'h10, 32'h0000_00A5, "R6 rxdata", 0);
    doWrite(8'h0C, 32'h0, 4'hF);
    doWrite(8'h10, 32'hFFFF_FFFF, 4'hF);
    doRead(8'h0C, 32'h8000_0010, "R6 status write ignored", 0);
    doRead(8'h10, 32'h0000_00A5, "R6 rx write ignored", 0);

    // R5 interrupt enables
    doWrite(8'h08, 32'hFFFF_FFFF, 4'hF);
    doRead(8'h08, 32'h0000_0011, "R5 enable readback", 0);
    doWrite(8'h08, 32'h0000_0010, 4'hF);
    check("R5 ready raises irq", {31'b0, irq}, 32'd1);
    @(negedge clk);
    seqReady = 0; seqDone = 1;
    @(negedge clk);
    check("R5 done masked", {31'b0, irq}, 32'd0);
    doWrite(8'h08, 32'h0000_0001, 4'hF);
    check("R5 done raises irq", {31'b0, irq}, 32'd1);
    @(negedge clk);
    seqDone = 0;
    check("R5 irq one edge late", {31'b0, irq}, 32'd1);
    @(negedge clk);
    check("R5 irq drops", {31'b0, irq}, 32'd0);
    doWrite(8'h08, 32'h0, 4'hF);

    // R8 pad mux
    @(negedge clk);
    seqPullLow = 1;
    @(negedge clk);
    check("R8 sequencer drives", {31'b0, padPullLow}, 32'd1);
    doWrite(8'h00, 32'h8001_0000, 4'hF);
    check("R8 bypass high releases", {31'b0, padPullLow}, 32'd0);
    doWrite(8'h00, 32'h8000_0000, 4'hF);
    seqPullLow = 0;
    @(negedge clk);
    check("R8 bypass low pulls", {31'b0, padPullLow}, 32'd1);
    doWrite(8'h00, 32'h8080_0000, 4'hF);
    check("R8 bypass input releases", {31'b0, padPullLow}, 32'd0);

    // R7 pin sample in bypass and sequencer mode
    @(negedge clk);
    padIn = 1;
    waitClk(3);
    doRead(8'h14, 32'h1, "R7 pin high bypass", 0);
    doWrite(8'h00, 32'h0, 4'hF);
    @(negedge clk);
    padIn = 0;
    waitClk(3);
    doRead(8'h14, 32'h0, "R7 pin low sequencer", 0);

    // R9 unmapped and unaligned
    doWrite(8'h00, 32'h0000_0C33, 4'hF);
    doWrite(8'h20, 32'hFFFF_FFFF, 4'hF);
    doWrite(8'h01, 32'hFFFF_FFFF, 4'hF);
    doWrite(8'h44, 32'hFFFF_FFFF, 4'hF);
    doRead(8'h00, 32'h0000_0C33, "R9 instr untouched", 0);
    doRead(8'h04, 32'h8000_0000, "R9 ctrl untouched", 0);
    doRead(8'h20, 32'h0, "R9 unmapped read", 0);
    doRead(8'h3A, 32'h0, "R9 unaligned read", 0);

    // R10 handshakes
    doRead(8'h1C, 32'h10EE_4453, "R10 held read", 3);
    @(negedge clk);
    axiAwAddr = 8'h04; axiWData = 32'h1; axiWStrb = 4'hF; axiAwValid = 1;
    @(negedge clk);
    check("R10 address alone not taken", {31'b0, axiAwReady}, 32'd0);
    @(negedge clk);
    check("R10 no response", {31'b0, axiBValid}, 32'd0);
    axiAwValid = 0;
    doWrite(8'h04, 32'h1, 4'hF);
    check("R10 later write applied", {31'b0, seqGo}, 32'd1);

    waitClk(2);
    cmpOn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule